// File: doc/BRIEF.md
# Doorbell Command Mailbox

A memory-mapped register block through which a host passes one command at a time to device-side logic. The host writes a 64-bit command word and any payload bytes, then rings a doorbell bit. The block raises a request to a command processor, takes back a 16-bit return code, stores that code in a read-only status register and clears the doorbell. The command processor here is a built-in stub. It answers one cycle after it sees the request: opcode zero succeeds and every other opcode is reported as unsupported.

The host side is a single-beat register bus. Each access carries a byte address, a size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes) and write data that is right-justified. Each access must be aligned to its own size. Read data comes back one cycle later, also right-justified. Every read of a 1-, 2- or 4-byte slice of wider storage returns exactly the addressed little-endian byte lanes.

Byte map: 0x00 is the capability word (32-bit, read-only), 0x04 is the control word (32-bit, doorbell at bit 0), 0x08 is the command register, 0x10 is the status register, 0x18 is the idle background-status register, and 0x20 up to 0x20 plus the window size is the payload window.

Top module: `cmd_mailbox_regs`

## Requirements
- R1: After reset the control, command, status and background-status registers read 0. The capability word reads log2 of the payload window size (0x0000000D for 8 KB).
- R2: A read returns its data on `bus_rvalid` in the cycle after the request. The addressed byte lanes are shifted down to bit 0, and the bits above the access size are zero.
- R3: A 4-byte write at 0x04 with bit 0 set raises the doorbell. Reads issued in each of the two cycles after that write show bit 0 set. From the third cycle on, it reads 0 again, because the processor has completed.
- R4: When the doorbell is serviced, status bits 47:32 take the return code and all other status bits stay 0. The code is 0x0000 when command bits 15:0 are zero and 0x0015 otherwise.
- R5: Writes of any size to the status or background-status registers change nothing, and they do not raise `bus_unimpl`.
- R6: Any aligned write of 1, 2, 4 or 8 bytes inside the payload window stores exactly its bytes. Those bytes read back, including at the last byte of the window. The write has no side effect on the doorbell.
- R7: While the doorbell is set, writes to the command register and to the payload window are ignored.
- R8: The control word accepts only 4-byte writes, and the command register accepts only 8-byte writes. Any other size at those offsets, or any 8-byte write at 0x00, is ignored and pulses `bus_unimpl` in the next cycle. A 4-byte write to the capability word is ignored without the flag.
- R9: A write above the payload window is ignored and pulses `bus_unimpl`. A read there returns 0.
- R10: A misaligned access changes no state, pulses `bus_err` in the next cycle and, if it is a read, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| bus_wdata | input | 64 | Right-justified write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 64 | Right-justified read data |
| bus_err | output | 1 | Misaligned access seen in the previous cycle |
| bus_unimpl | output | 1 | Unexpected write ignored in the previous cycle |

## Verification
The assertions rely on the host issuing at most one access per cycle, and on `bus_size` and `bus_addr` being stable while `bus_valid` is high. They also assume the host does not try to set the doorbell in the very cycle its completion clears it. The stimulus drives every access on the falling clock edge for exactly one cycle. After a doorbell write, the bench only issues reads or writes that the block must reject until completion has been observed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned REG_SPAN = 32;   // payload window starts here
  localparam logic [15:0] RC_OK          = 16'h0000;
  localparam logic [15:0] RC_UNSUPPORTED = 16'h0015;
  localparam logic [1:0]  SZ_B4 = 2'd2;
  localparam logic [1:0]  SZ_B8 = 2'd3;

  typedef enum logic [2:0] {
    RG_SLOT0, RG_CMD, RG_STS, RG_BG, RG_PAY, RG_NONE
  } region_e;

  function automatic logic [7:0] lane_mask(logic [2:0] off, logic [1:0] sz);
    logic [7:0] m;
    case (sz)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      2'd2:    m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m << off;
  endfunction

  function automatic logic is_aligned(logic [2:0] off, logic [1:0] sz);
    logic ok;
    case (sz)
      2'd0:    ok = 1'b1;
      2'd1:    ok = (off[0] == 1'b0);
      2'd2:    ok = (off[1:0] == 2'b00);
      default: ok = (off == 3'b000);
    endcase
    return ok;
  endfunction

  function automatic logic [63:0] place_lanes(logic [63:0] d, logic [2:0] off);
    return d << {off, 3'b000};
  endfunction

  function automatic logic [63:0] pick_lanes(logic [63:0] w, logic [2:0] off,
                                             logic [1:0] sz);
    logic [63:0] s;
    logic [63:0] r;
    s = w >> {off, 3'b000};
    case (sz)
      2'd0:    r = {56'b0, s[7:0]};
      2'd1:    r = {48'b0, s[15:0]};
      2'd2:    r = {32'b0, s[31:0]};
      default: r = s;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] stub_code(logic [15:0] opcode);
    return (opcode == 16'h0000) ? RC_OK : RC_UNSUPPORTED;
  endfunction

endpackage

// File: rtl/mbx_access_decode.sv
module mbx_access_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned PAY_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              busy,
  output region_e           region,
  output logic              misalign,
  output logic              ctrl_we,
  output logic              cmd_we,
  output logic              pay_we,
  output logic              unimpl_wr
);

  localparam logic [ADDR_W:0] PAY_LO = (ADDR_W+1)'(REG_SPAN);
  localparam logic [ADDR_W:0] PAY_HI = (ADDR_W+1)'(REG_SPAN + PAY_BYTES);

  logic [ADDR_W:0] addr_ext;
  logic            wr_ok;

  assign addr_ext = {1'b0, acc_addr};
  assign misalign = acc_valid & ~is_aligned(acc_addr[2:0], acc_size);
  assign wr_ok    = acc_valid & acc_write & ~misalign;

  always_comb begin
    if (addr_ext >= PAY_HI)      region = RG_NONE;
    else if (addr_ext >= PAY_LO) region = RG_PAY;
    else begin
      case (acc_addr[4:3])
        2'd0:    region = RG_SLOT0;
        2'd1:    region = RG_CMD;
        2'd2:    region = RG_STS;
        default: region = RG_BG;
      endcase
    end
  end

  always_comb begin
    ctrl_we   = 1'b0;
    cmd_we    = 1'b0;
    pay_we    = 1'b0;
    unimpl_wr = 1'b0;
    if (wr_ok) begin
      case (region)
        RG_SLOT0: begin
          if (acc_size == SZ_B4 && acc_addr[2])       ctrl_we   = 1'b1;
          else if (!(acc_size == SZ_B4 && !acc_addr[2])) unimpl_wr = 1'b1;
        end
        RG_CMD: begin
          if (acc_size == SZ_B8) cmd_we    = ~busy;
          else                   unimpl_wr = 1'b1;
        end
        RG_STS, RG_BG: ;
        RG_PAY:  pay_we    = ~busy;
        default: unimpl_wr = 1'b1;
      endcase
    end
  end

  // R8: a single write produces at most one action
  assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, cmd_we, pay_we, unimpl_wr}));

  // R10: a misaligned access never enables storage
  assert_misalign_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !(ctrl_we || cmd_we || pay_we));

  // R7: busy blocks command and payload stores
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(cmd_we || pay_we));

endmodule

// File: rtl/mbx_payload_store.sv
module mbx_payload_store #(
  parameter int unsigned WORDS = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       byte_en,
  input  logic [63:0]      wdata,
  output logic [63:0]      rdata
);

  logic [63:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 8; b++) begin
        if (byte_en[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/mbx_cmd_stub.sv
module mbx_cmd_stub
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [15:0] opcode,
  output logic        done,
  output logic [15:0] ret_code
);

  logic        done_q;
  logic [15:0] rc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rc_q   <= RC_OK;
    end else begin
      done_q <= req;
      if (req) rc_q <= stub_code(opcode);
    end
  end

  assign done     = done_q;
  assign ret_code = rc_q;

  // R3: a request is answered in the next cycle
  assert_answer_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);

  // R4: completion is a one-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/cmd_mailbox_regs.sv
module cmd_mailbox_regs
  import mbx_pkg::*;
#(
  parameter int unsigned PAY_BYTES = 8192,
  parameter int unsigned ADDR_W    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [63:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [63:0]       bus_rdata,
  output logic              bus_err,
  output logic              bus_unimpl
);

  localparam int unsigned PAY_WORDS = PAY_BYTES / 8;
  localparam int unsigned IDX_W     = $clog2(PAY_WORDS);
  localparam logic [31:0] CAP_WORD  = 32'($clog2(PAY_BYTES));

  region_e          region;
  logic             misalign, ctrl_we, cmd_we, pay_we, unimpl_wr;
  logic             stub_req, stub_done;
  logic [15:0]      stub_rc;
  logic             db_q;
  logic [63:0]      cmd_q;
  logic [15:0]      rc_q;
  logic [IDX_W-1:0] pay_idx;
  logic [63:0]      pay_rdata;
  logic [63:0]      status_word;
  logic [63:0]      read_word;
  logic             rd_fire;
  logic             rvalid_q, err_q, unimpl_q;
  logic [63:0]      rdata_q;

  mbx_access_decode #(.ADDR_W(ADDR_W), .PAY_BYTES(PAY_BYTES)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(bus_valid), .acc_write(bus_write),
    .acc_addr(bus_addr), .acc_size(bus_size), .busy(db_q),
    .region(region), .misalign(misalign),
    .ctrl_we(ctrl_we), .cmd_we(cmd_we), .pay_we(pay_we), .unimpl_wr(unimpl_wr)
  );

  assign pay_idx = IDX_W'((bus_addr - ADDR_W'(REG_SPAN)) >> 3);

  mbx_payload_store #(.WORDS(PAY_WORDS)) u_payload (
    .clk(clk), .we(pay_we), .idx(pay_idx),
    .byte_en(lane_mask(bus_addr[2:0], bus_size)),
    .wdata(place_lanes(bus_wdata, bus_addr[2:0])),
    .rdata(pay_rdata)
  );

  assign stub_req = db_q & ~stub_done;

  mbx_cmd_stub u_stub (
    .clk(clk), .rst_n(rst_n), .req(stub_req), .opcode(cmd_q[15:0]),
    .done(stub_done), .ret_code(stub_rc)
  );

  // doorbell: host may only set it, completion clears it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q  <= 1'b0;
      cmd_q <= '0;
      rc_q  <= RC_OK;
    end else begin
      if (stub_done)                   db_q <= 1'b0;
      else if (ctrl_we && bus_wdata[0]) db_q <= 1'b1;
      if (cmd_we)    cmd_q <= bus_wdata;
      if (stub_done) rc_q  <= stub_rc;
    end
  end

  assign status_word = {16'b0, rc_q, 32'b0};

  always_comb begin
    case (region)
      RG_SLOT0: read_word = {31'b0, db_q, CAP_WORD};
      RG_CMD:   read_word = cmd_q;
      RG_STS:   read_word = status_word;
      RG_PAY:   read_word = pay_rdata;
      default:  read_word = '0;
    endcase
  end

  assign rd_fire = bus_valid & ~bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
      unimpl_q <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      err_q    <= misalign;
      unimpl_q <= unimpl_wr;
      if (rd_fire)
        rdata_q <= misalign ? 64'b0 : pick_lanes(read_word, bus_addr[2:0], bus_size);
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;
  assign bus_err    = err_q;
  assign bus_unimpl = unimpl_q;

  // R2: every read is answered one cycle later
  assert_read_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> bus_rvalid);

  // R3: completion drops the doorbell
  assert_db_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stub_done |=> !db_q);

  // R5: status only changes on completion
  assert_status_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stub_done |=> $stable(rc_q));

  // R7: command frozen while doorbell set
  assert_cmd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    db_q |=> $stable(cmd_q));

  // R10: misaligned access leaves command and doorbell set-state alone
  assert_misalign_no_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> ($stable(cmd_q) && bus_err));

endmodule

// File: tb/cmd_mailbox_regs_test.sv
`timescale 1ns/1ps
module cmd_mailbox_regs_test;

  localparam int ADDR_W = 14;
  localparam int NV = 19;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [1:0]        bus_size = '0;
  logic [63:0]       bus_wdata = '0;
  logic              bus_rvalid, bus_err, bus_unimpl;
  logic [63:0]       bus_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmd_mailbox_regs #(.PAY_BYTES(8192), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .bus_unimpl(bus_unimpl)
  );

  // {tag[4], write, size[2], addr[14], wdata[64], expected read[64]}
  localparam logic [148:0] VEC [NV] = '{
    {4'd1, 1'b0, 2'd2, 14'h0000, 64'h0, 64'h0000_0000_0000_000D},  // R1 capability
    {4'd1, 1'b0, 2'd2, 14'h0004, 64'h0, 64'h0},                    // R1 control
    {4'd2, 1'b1, 2'd3, 14'h0008, 64'h0011_2233_4455_6677, 64'h0},
    {4'd2, 1'b0, 2'd0, 14'h000B, 64'h0, 64'h44},                   // R2 byte 3
    {4'd2, 1'b0, 2'd1, 14'h000E, 64'h0, 64'h0011},                 // R2 half 3
    {4'd2, 1'b0, 2'd2, 14'h000C, 64'h0, 64'h0011_2233},            // R2 upper word
    {4'd2, 1'b0, 2'd3, 14'h0008, 64'h0, 64'h0011_2233_4455_6677},  // R2 full
    {4'd5, 1'b1, 2'd3, 14'h0010, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {4'd5, 1'b0, 2'd3, 14'h0010, 64'h0, 64'h0},                    // R5 status
    {4'd5, 1'b1, 2'd2, 14'h0018, 64'hFFFF_FFFF, 64'h0},
    {4'd5, 1'b0, 2'd3, 14'h0018, 64'h0, 64'h0},                    // R5 background
    {4'd6, 1'b1, 2'd0, 14'h0020, 64'hA5, 64'h0},
    {4'd6, 1'b1, 2'd0, 14'h0021, 64'h5A, 64'h0},
    {4'd6, 1'b1, 2'd1, 14'h0022, 64'hBEEF, 64'h0},
    {4'd6, 1'b1, 2'd2, 14'h0024, 64'h1234_5678, 64'h0},
    {4'd6, 1'b0, 2'd3, 14'h0020, 64'h0, 64'h1234_5678_BEEF_5AA5},  // R6 mixed sizes
    {4'd6, 1'b1, 2'd3, 14'h2018, 64'hCAFE_F00D_0BAD_BEEF, 64'h0},
    {4'd6, 1'b0, 2'd0, 14'h201F, 64'h0, 64'hCA},                   // R6 last byte
    {4'd6, 1'b0, 2'd2, 14'h0004, 64'h0, 64'h0}                     // R6 no doorbell
  };

  logic [63:0] rd;
  logic        er, un;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic bus_op(input logic wr, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                        input logic [63:0] wd, output logic [63:0] rdat,
                        output logic err, output logic unimp);
    bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rdat = bus_rdata; err = bus_err; unimp = bus_unimpl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of command and status
    bus_op(1'b0, 2'd3, 14'h0008, 64'h0, rd, er, un); check("R1 command reset", rd, 64'h0);
    bus_op(1'b0, 2'd3, 14'h0010, 64'h0, rd, er, un); check("R1 status reset", rd, 64'h0);
    check("R2 rvalid after read", {63'b0, bus_rvalid}, 64'h1);

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][144], VEC[i][143:142], VEC[i][141:128], VEC[i][127:64], rd, er, un);
      if (!VEC[i][144]) begin
        checks++;
        if (rd !== VEC[i][63:0]) begin
          errors++;
          $display("FAIL R%0d vector %0d actual %h expected %h",
                   VEC[i][148:145], i, rd, VEC[i][63:0]);
        end
      end
    end

    // R5 status write raises no flag
    bus_op(1'b1, 2'd3, 14'h0010, 64'h1, rd, er, un); check("R5 no unimpl", {63'b0, un}, 64'h0);

    // R3 R4 R7 doorbell with unsupported opcode 0x6677
    bus_op(1'b1, 2'd2, 14'h0004, 64'h1, rd, er, un);
    bus_op(1'b0, 2'd2, 14'h0004, 64'h0, rd, er, un); check("R3 doorbell set", rd, 64'h1);
    bus_op(1'b1, 2'd0, 14'h0020, 64'hFF, rd, er, un);
    bus_op(1'b0, 2'd2, 14'h0004, 64'h0, rd, er, un); check("R3 doorbell cleared", rd, 64'h0);
    bus_op(1'b0, 2'd3, 14'h0010, 64'h0, rd, er, un); check("R4 unsupported code", rd, 64'h0000_0015_0000_0000);
    bus_op(1'b0, 2'd0, 14'h0020, 64'h0, rd, er, un); check("R7 payload kept", rd, 64'hA5);

    // R4 R7 opcode zero succeeds, command write while busy dropped
    bus_op(1'b1, 2'd3, 14'h0008, 64'h0000_0001_0000_0000, rd, er, un);
    bus_op(1'b1, 2'd2, 14'h0004, 64'h1, rd, er, un);
    bus_op(1'b0, 2'd0, 14'h0004, 64'h0, rd, er, un); check("R3 doorbell byte read", rd, 64'h1);
    bus_op(1'b1, 2'd3, 14'h0008, 64'hFFFF, rd, er, un);
    bus_op(1'b0, 2'd2, 14'h0004, 64'h0, rd, er, un); check("R3 doorbell cleared again", rd, 64'h0);
    bus_op(1'b0, 2'd3, 14'h0010, 64'h0, rd, er, un); check("R4 success code", rd, 64'h0);
    bus_op(1'b0, 2'd3, 14'h0008, 64'h0, rd, er, un); check("R7 command kept", rd, 64'h0000_0001_0000_0000);

    // R8 size filtering
    bus_op(1'b1, 2'd3, 14'h0000, 64'h1_0000_0001, rd, er, un); check("R8 8B at slot0 flagged", {63'b0, un}, 64'h1);
    bus_op(1'b1, 2'd1, 14'h0004, 64'h1, rd, er, un); check("R8 2B ctrl flagged", {63'b0, un}, 64'h1);
    bus_op(1'b0, 2'd2, 14'h0004, 64'h0, rd, er, un); check("R8 doorbell not set", rd, 64'h0);
    bus_op(1'b1, 2'd2, 14'h0008, 64'h9999, rd, er, un); check("R8 4B cmd flagged", {63'b0, un}, 64'h1);
    bus_op(1'b1, 2'd2, 14'h0000, 64'h7777, rd, er, un); check("R8 cap write quiet", {63'b0, un}, 64'h0);
    bus_op(1'b0, 2'd2, 14'h0000, 64'h0, rd, er, un); check("R8 cap unchanged", rd, 64'hD);
    bus_op(1'b0, 2'd3, 14'h0008, 64'h0, rd, er, un); check("R8 cmd unchanged", rd, 64'h0000_0001_0000_0000);

    // R9 beyond the window
    bus_op(1'b1, 2'd2, 14'h2020, 64'h5555, rd, er, un); check("R9 unmapped flagged", {63'b0, un}, 64'h1);
    bus_op(1'b0, 2'd2, 14'h2020, 64'h0, rd, er, un); check("R9 unmapped reads zero", rd, 64'h0);

    // R10 misaligned
    bus_op(1'b1, 2'd2, 14'h0022, 64'hFFFF_FFFF, rd, er, un); check("R10 write err", {63'b0, er}, 64'h1);
    bus_op(1'b0, 2'd1, 14'h0021, 64'h0, rd, er, un); check("R10 read err", {63'b0, er}, 64'h1);
    check("R10 read zero", rd, 64'h0);
    bus_op(1'b0, 2'd2, 14'h0020, 64'h0, rd, er, un); check("R10 payload intact", rd, 64'hBEEF_5AA5);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule